// File: doc/BRIEF.md
# Timer Capture/Compare Pin Channel

This block is one capture/compare channel that sits beside a free-running timer counter. It holds one general register of counter width and a 4-bit mode field. When the top bit of the mode is 0, the channel compares the counter against the register and drives a pin. When the top bit is 1, it copies the counter into the register on a selected event. The counter itself is outside the block. The block sees only its value, a count-enable strobe, the pin input, a count-event pulse from a neighbouring cascaded counter, a buffer-mode flag and a flag saying that the neighbour runs from the undivided clock.

In the output modes, each code carries two things: a starting pin level, set from mode bit 2, and a match action, set from mode bits 1:0. In the capture modes, the pin is never driven. A capture source is either a synchronized edge of the pin input or a count event from the neighbour. Two configuration conditions silence the channel without any error: the buffer-mode flag, and a neighbour that runs from the undivided clock. Each compare match and each capture raises a single-cycle event flag.

Top module: `tmr_ccp_channel`

## Requirements
- R1: While reset is asserted, pin_out, pin_oe and evt_flag are 0 and gr_val is 0.
- R2: A write with mode_wr loads mode_in. On the next clock edge the pin takes its starting level. For codes 0xxx this level is mode bit 2; for codes 1xxx it is 0. pin_oe is 1 exactly for codes 0001, 0010, 0011, 0101, 0110 and 0111.
- R3: In an output mode a compare match acts on the pin at the next edge. Action bits 01 drive 0, 10 drive 1 and 11 toggle. Without a match or a mode write, the pin holds its level.
- R4: A compare match occurs only in a cycle where cnt_en is 1 and cnt_val equals the register. With cnt_en at 0, no flag is raised and the pin does not change.
- R5: Each match or capture sets evt_flag to 1 for exactly one cycle, starting with the edge that acts on it.
- R6: Mode 1000 captures on a rising edge of pin_in and mode 1001 on a falling edge. A pin_in change sampled at edge k is captured at edge k+2, and the value taken is cnt_val from the cycle before that edge.
- R7: Modes 1010 and 1011 capture on both edges of pin_in, with the same timing as R6.
- R8: Modes 11xx ignore pin_in. They capture cnt_val at the edge where nbr_evt is 1.
- R9: In modes 11xx with nbr_fast at 1, nbr_evt captures nothing and raises no flag.
- R10: While buf_mode is 1, no capture and no compare match happens: the register, the pin and evt_flag stay unchanged.
- R11: reg_wr loads reg_in into the register at the next edge. A capture in the same cycle takes priority. gr_val always shows the register.
- R12: In codes 0000 and 0100 a match raises evt_flag but leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load strobe for mode_in |
| mode_in | input | 4 | New mode code |
| reg_wr | input | 1 | Load strobe for reg_in |
| reg_in | input | 16 | New general register value |
| cnt_val | input | 16 | Current timer counter value |
| cnt_en | input | 1 | Counter count-enable strobe |
| pin_in | input | 1 | Asynchronous pin input |
| nbr_evt | input | 1 | Count-up or count-down pulse of the neighbour counter |
| buf_mode | input | 1 | Register is used as a buffer; channel events suppressed |
| nbr_fast | input | 1 | Neighbour counts on the undivided clock |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin output enable |
| evt_flag | output | 1 | One-cycle match/capture event |
| gr_val | output | 16 | General register contents |

## Verification
Three results fall due one edge after their cause: a mode write, a register write, and the action of a compare match or a neighbour capture on the pin and the flag. A pin-edge capture falls due three sampled cycles after the input changes, because of the two synchronizer stages and the edge register. The flag is due to drop one cycle after that. The driver tasks put each expected value into the scoreboard queue together with its due cycle, counted from the cycle in which the stimulus was applied. The monitor compares every entry in the queue on the falling edge of the cycle when that entry falls due. In the capture phases the counter value advances by one each cycle, so a value taken one cycle early or late shows up as a wrong register value.

// File: rtl/tccp_pkg.sv
package tccp_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  // Starting pin level for a freshly written mode.
  function automatic logic start_level(input logic is_cap, input logic lvl_bit);
    return !is_cap && lvl_bit;
  endfunction

  // Output enable: output mode with a real match action.
  function automatic logic drive_on(input logic is_cap, input logic [1:0] act);
    return !is_cap && (act != ACT_HOLD);
  endfunction

  // Pin level after a compare match.
  function automatic logic next_pin(input logic [1:0] act, input logic cur);
    case (act_e'(act))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return !cur;
      default:  return cur;
    endcase
  endfunction

  // Pin-edge selection for capture codes 10xx.
  function automatic logic pin_hit(input logic [1:0] sel, input logic rise, input logic fall);
    if (sel[1]) return rise || fall;
    return sel[0] ? fall : rise;
  endfunction
endpackage

// File: rtl/tccp_edge_sync.sv
module tccp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[DEPTH-2:0], din};
  end

  assign rise = shreg[STAGES-1] && !shreg[STAGES];
  assign fall = !shreg[STAGES-1] && shreg[STAGES];
endmodule

// File: rtl/tccp_cmp.sv
module tccp_cmp
  import tccp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_new,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_en,
  input  logic [CNT_W-1:0]  gr_q,
  input  logic              buf_mode,
  output logic              match,
  output logic              pin_q
);
  assign match = !mode_q[3] && !buf_mode && cnt_en && (cnt_val == gr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       pin_q <= 1'b0;
    else if (mode_wr) pin_q <= start_level(mode_new[3], mode_new[2]);
    else if (match)   pin_q <= next_pin(mode_q[1:0], pin_q);
  end

  AST_PIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr && !match) |=> $stable(pin_q)); // R3
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr && match && mode_q[1:0] == 2'b11) |=> (pin_q != $past(pin_q))); // R3
  AST_DISABLED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr && mode_q[1:0] == 2'b00) |=> $stable(pin_q)); // R12
endmodule

// File: rtl/tccp_cap.sv
module tccp_cap
  import tccp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              rise,
  input  logic              fall,
  input  logic              nbr_evt,
  input  logic              nbr_fast,
  input  logic              buf_mode,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_in,
  output logic              cap_fire,
  output logic [CNT_W-1:0]  gr_q
);
  logic src_hit;

  always_comb begin
    if (mode_q[2]) src_hit = nbr_evt && !nbr_fast;
    else           src_hit = pin_hit(mode_q[1:0], rise, fall);
  end

  assign cap_fire = mode_q[3] && !buf_mode && src_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        gr_q <= '0;
    else if (cap_fire) gr_q <= cnt_val;
    else if (reg_wr)   gr_q <= reg_in;
  end

  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (gr_q == $past(cnt_val))); // R6
  AST_GR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && !reg_wr) |=> $stable(gr_q)); // R11
endmodule

// File: rtl/tmr_ccp_channel.sv
module tmr_ccp_channel
  import tccp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [3:0]        mode_in,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_in,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_en,
  input  logic              pin_in,
  input  logic              nbr_evt,
  input  logic              buf_mode,
  input  logic              nbr_fast,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              evt_flag,
  output logic [CNT_W-1:0]  gr_val
);
  logic [MODE_W-1:0] mode_q;
  logic              rise_w, fall_w;
  logic              match_w, cap_w;
  logic              pin_w, evt_q;
  logic [CNT_W-1:0]  gr_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_in;
      evt_q <= match_w || cap_w;
    end
  end

  tccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(rise_w), .fall(fall_w)
  );

  tccp_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_new(mode_in),
    .mode_q(mode_q), .cnt_val(cnt_val), .cnt_en(cnt_en), .gr_q(gr_w),
    .buf_mode(buf_mode), .match(match_w), .pin_q(pin_w)
  );

  tccp_cap #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .rise(rise_w), .fall(fall_w),
    .nbr_evt(nbr_evt), .nbr_fast(nbr_fast), .buf_mode(buf_mode),
    .cnt_val(cnt_val), .reg_wr(reg_wr), .reg_in(reg_in),
    .cap_fire(cap_w), .gr_q(gr_w)
  );

  assign pin_out  = pin_w;
  assign pin_oe   = drive_on(mode_q[3], mode_q[1:0]);
  assign evt_flag = evt_q;
  assign gr_val   = gr_w;

  AST_OE_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !mode_q[3]); // R2
  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !mode_q[3]) |=> !evt_flag); // R4
  AST_BUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |=> !evt_flag); // R10
  AST_FAST_NBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b11 && nbr_fast) |=> !evt_flag); // R9
endmodule

// File: tb/test_tmr_ccp_channel.sv
module test_tmr_ccp_channel;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, mode_wr = 1'b0, reg_wr = 1'b0, cnt_en = 1'b0;
  logic        pin_in = 1'b0, nbr_evt = 1'b0, buf_mode = 1'b0, nbr_fast = 1'b0;
  logic [3:0]  mode_in = '0;
  logic [15:0] reg_in = '0, cnt_val = '0;
  logic        pin_out, pin_oe, evt_flag;
  logic [15:0] gr_val;

  tmr_ccp_channel i_tmr_ccp_channel (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .reg_wr(reg_wr), .reg_in(reg_in), .cnt_val(cnt_val), .cnt_en(cnt_en),
    .pin_in(pin_in), .nbr_evt(nbr_evt), .buf_mode(buf_mode), .nbr_fast(nbr_fast),
    .pin_out(pin_out), .pin_oe(pin_oe), .evt_flag(evt_flag), .gr_val(gr_val)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int sel; logic [15:0] val; string req; } exp_t;
  exp_t sbq[$];
  int checks = 0, errors = 0;
  bit done = 0, free_run = 0;
  logic [15:0] gr_model = '0;
  logic        pin_model = 1'b0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0: return {15'd0, pin_out};
      1: return {15'd0, pin_oe};
      2: return {15'd0, evt_flag};
      default: return gr_val;
    endcase
  endfunction

  task automatic check(string req, int sel, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h", req, sel, cyc, act, exp);
    end
  endtask

  task automatic expect_at(int delta, int sel, logic [15:0] val, string req);
    sbq.push_back('{cyc + delta, sel, val, req});
  endtask

  // Monitor: compares every queued item on the falling edge of its due cycle.
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        check(sbq[i].req, sbq[i].sel, observe(sbq[i].sel), sbq[i].val);
        sbq.delete(i);
      end
    end
  end

  // Free-running counter stand-in: value is 0x1000 + cycle index.
  always @(negedge clk) begin
    #1;
    if (free_run) cnt_val = 16'(32'h1000 + cyc);
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic do_mode(logic [3:0] m, logic ep, logic eo, string req);
    step();
    mode_wr = 1'b1; mode_in = m;
    expect_at(1, 0, {15'd0, ep}, req);
    expect_at(1, 1, {15'd0, eo}, req);
    pin_model = ep;
    step();
    mode_wr = 1'b0;
  endtask

  task automatic do_match(logic en, logic ep, logic ee, string req);
    step();
    cnt_val = gr_model; cnt_en = en;
    expect_at(1, 0, {15'd0, ep}, req);
    expect_at(1, 2, {15'd0, ee}, req);
    pin_model = ep;
    step();
    cnt_en = 1'b0; cnt_val = ~gr_model;
    expect_at(1, 2, 16'd0, "R5");
    expect_at(1, 0, {15'd0, ep}, "R3");
  endtask

  task automatic do_pin(logic v, logic fires, string req);
    step();
    pin_in = v;
    if (fires) gr_model = 16'(32'h1000 + cyc + 2);
    expect_at(3, 3, gr_model, req);
    expect_at(3, 2, {15'd0, fires}, req);
    expect_at(4, 2, 16'd0, "R5");
    repeat (5) step();
  endtask

  task automatic do_nbr(logic fires, string req);
    step();
    nbr_evt = 1'b1;
    if (fires) gr_model = 16'(32'h1000 + cyc);
    expect_at(1, 3, gr_model, req);
    expect_at(1, 2, {15'd0, fires}, req);
    step();
    nbr_evt = 1'b0;
    expect_at(1, 2, 16'd0, "R5");
    repeat (2) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, {15'd0, pin_out}, 16'd0);
    check("R1", 1, {15'd0, pin_oe}, 16'd0);
    check("R1", 2, {15'd0, evt_flag}, 16'd0);
    check("R1", 3, gr_val, 16'd0);
    #2 rst_n = 1'b1;

    // R11: register write
    step();
    reg_wr = 1'b1; reg_in = 16'h0040; gr_model = 16'h0040;
    expect_at(1, 3, 16'h0040, "R11");
    step();
    reg_wr = 1'b0; cnt_val = 16'h0000;

    // Output compare modes
    do_mode(4'b0101, 1'b1, 1'b1, "R2");
    do_match(1'b0, 1'b1, 1'b0, "R4");
    do_match(1'b1, 1'b0, 1'b1, "R3");
    do_mode(4'b0011, 1'b0, 1'b1, "R2");
    do_match(1'b1, 1'b1, 1'b1, "R3");
    do_match(1'b1, 1'b0, 1'b1, "R3");
    do_mode(4'b0110, 1'b1, 1'b1, "R2");
    do_match(1'b1, 1'b1, 1'b1, "R3");
    do_mode(4'b0010, 1'b0, 1'b1, "R2");
    do_match(1'b1, 1'b1, 1'b1, "R3");
    do_mode(4'b0111, 1'b1, 1'b1, "R2");
    do_match(1'b1, 1'b0, 1'b1, "R3");
    do_mode(4'b0001, 1'b0, 1'b1, "R2");
    do_match(1'b1, 1'b0, 1'b1, "R3");
    do_mode(4'b0100, 1'b1, 1'b0, "R12");
    do_match(1'b1, 1'b1, 1'b1, "R12");
    do_mode(4'b0000, 1'b0, 1'b0, "R12");
    do_match(1'b1, 1'b0, 1'b1, "R12");
    do_mode(4'b0011, 1'b0, 1'b1, "R2");
    buf_mode = 1'b1;
    do_match(1'b1, 1'b0, 1'b0, "R10");
    buf_mode = 1'b0;

    // Input capture modes
    free_run = 1'b1;
    do_mode(4'b1000, 1'b0, 1'b0, "R2");
    do_pin(1'b1, 1'b1, "R6");
    do_pin(1'b0, 1'b0, "R6");
    do_mode(4'b1001, 1'b0, 1'b0, "R2");
    do_pin(1'b1, 1'b0, "R6");
    do_pin(1'b0, 1'b1, "R6");
    do_mode(4'b1010, 1'b0, 1'b0, "R2");
    do_pin(1'b1, 1'b1, "R7");
    do_pin(1'b0, 1'b1, "R7");
    do_mode(4'b1011, 1'b0, 1'b0, "R2");
    do_pin(1'b1, 1'b1, "R7");
    do_mode(4'b1100, 1'b0, 1'b0, "R2");
    do_pin(1'b0, 1'b0, "R8");
    do_nbr(1'b1, "R8");
    nbr_fast = 1'b1;
    do_nbr(1'b0, "R9");
    nbr_fast = 1'b0;
    do_mode(4'b1110, 1'b0, 1'b0, "R2");
    do_nbr(1'b1, "R8");
    do_mode(4'b1010, 1'b0, 1'b0, "R2");
    buf_mode = 1'b1;
    do_pin(1'b1, 1'b0, "R10");
    buf_mode = 1'b0;

    repeat (6) step();
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R5 pending items actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule